// File: doc/BRIEF.md
# Banked Register-Mapped GPIO Controller

This block is a general-purpose I/O peripheral that groups its pins into banks of 32 and exposes each bank as a window of ten 32-bit registers on a plain word read/write bus. Software uses the windows to choose pin direction, drive output levels, sample input levels and arm edge detection. Each pin can be armed separately for rising edges and for falling edges. A detected edge latches a sticky status bit, and any set status bit raises one combined interrupt request line.

Output levels can be written whole, or changed with write-one-to-set and write-one-to-clear accesses. These touch only the selected pins, so no read-modify-write sequence is needed. Pin levels enter through a two-flop synchronizer. The input register and the edge detectors both see that synchronized view, so a change at a pin takes two clock edges to show up in a read. The pin count is a parameter and need not be a multiple of 32. In the last bank only the populated bits exist. Bank windows that hold no pins, and every other address outside the windows, read as zero and ignore writes.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset every direction bit of an implemented pin is 1 (all pins inputs, `pin_oe` all 0). Output latches, rising and falling enables and interrupt status are all 0, and `irq` is 0.
- R2: A direction bit of 1 makes the pin an input (`pin_oe` low for it). A 0 makes it an output (`pin_oe` high). The direction register changes only when it is written.
- R3: A write to the set-data register (bank offset 0x08) sets to 1 every output latch bit whose write-data bit is 1 and leaves all other bits unchanged. `pin_out` always shows the latch.
- R4: A write to the clear-data register (bank offset 0x0C) clears to 0 every output latch bit whose write-data bit is 1 and leaves all other bits unchanged.
- R5: The input-data register (offset 0x10) returns the synchronized level of every implemented pin, outputs included. A level present at the pin before clock edge t is returned by reads after edge t+1, and not before.
- R6: Bank b occupies byte addresses 0x10 + 0x28*b up to 0x10 + 0x28*b + 0x24. The word offsets inside a bank are: 0x00 direction, 0x04 output data (read/write, a write replaces the latch), 0x08 set data, 0x0C clear data, 0x10 input data, 0x14 rising-enable set, 0x18 rising-enable clear, 0x1C falling-enable set, 0x20 falling-enable clear, 0x24 interrupt status. Reads of 0x08 and 0x0C return the output latch. `bus_rdata` is combinational in `bus_addr`, and writes take effect at the clock edge on which `bus_wr_en` is high.
- R7: Writing 1s at 0x14 or 0x1C enables rising or falling detection for those pins. Writing 1s at 0x18 or 0x20 disables it. Reads of 0x14 and 0x18 both return the rising-enable mask, and reads of 0x1C and 0x20 both return the falling-enable mask.
- R8: When the synchronized level goes 0 to 1 with rising enabled, or 1 to 0 with falling enabled, the pin's status bit becomes 1 on the edge after the synchronizer output changes. For a pin level changed before edge t, status reads 1 after edge t+2. Writing 1 to a status bit clears it. A new edge in the same cycle keeps the bit set.
- R9: `irq` is high exactly when some status bit in some bank is 1.
- R10: In the partially populated last bank, register bits above the pin count read 0 and ignore writes. Only the populated pins are driven.
- R11: Addresses below 0x10, addresses beyond the last populated bank's window, and addresses with either of the two low bits set read 0. Writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for registers and synchronizer |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr_en | input | 1 | Write strobe, applied at the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| pin_in | input | NUM_PINS | Asynchronous pin levels |
| pin_out | output | NUM_PINS | Output latch levels |
| pin_oe | output | NUM_PINS | Output enable per pin (1 = drive) |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with NUM_PINS = 80 and ADDR_W = 8. This gives two full banks and a third bank with only 16 pins, so the masking of the upper half of a register is exercised in R10. It also places the windows at 0x88 and 0xB0 outside the populated range, and those two windows must read and write like the gap below 0x10 (R11). A behavioural model compares every output and the read data on every cycle. It covers directed sequences for synchronizer latency and edge timing, and a long stretch of random register traffic with random pin activity.

// File: rtl/gpio_pkg.sv
// gpio_pkg: shared constants and types for the banked GPIO controller.
// Assumes a 32-bit data bus and at most five banks of 32 pins.
package gpio_pkg;
    localparam int BUS_W         = 32;
    localparam int PINS_PER_BANK = 32;
    localparam int MAX_BANKS     = 5;
    localparam int BANK_BASE     = 16;   // byte address of bank 0
    localparam int BANK_STRIDE   = 40;   // bytes between bank windows
    localparam int REGS_PER_BANK = 10;

    // Register order inside a bank window (word offsets 0..9).
    typedef enum logic [3:0] {
        REG_DIR      = 4'd0,
        REG_OUT      = 4'd1,
        REG_SET      = 4'd2,
        REG_CLR      = 4'd3,
        REG_IN       = 4'd4,
        REG_RISE_SET = 4'd5,
        REG_RISE_CLR = 4'd6,
        REG_FALL_SET = 4'd7,
        REG_FALL_CLR = 4'd8,
        REG_STAT     = 4'd9
    } gpio_reg_e;

    typedef struct packed {
        logic      hit;
        logic [2:0] bank;
        gpio_reg_e regsel;
    } gpio_dec_t;
endpackage

// File: rtl/gpio_addr_dec.sv
// gpio_addr_dec: maps a byte address onto (bank, register) for the populated
// banks. Assumes ADDR_W is wide enough to reach the last window (8 bits for
// five banks). Misaligned addresses and addresses outside every window miss.
module gpio_addr_dec
    import gpio_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int NUM_BANKS = 5
) (
    input  logic [ADDR_W-1:0] addr,
    output gpio_dec_t         dec
);
    localparam int WIN_BYTES = 4 * REGS_PER_BANK;

    // Range compare against each window; at most one window can match.
    always_comb begin
        dec = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if ((32'(addr) >= 32'(BANK_BASE + b * BANK_STRIDE)) &&
                (32'(addr) <  32'(BANK_BASE + b * BANK_STRIDE + WIN_BYTES)) &&
                (addr[1:0] == 2'b00)) begin
                dec.hit    = 1'b1;
                dec.bank   = 3'(b);
                dec.regsel = gpio_reg_e'(4'((32'(addr) - 32'(BANK_BASE + b * BANK_STRIDE)) >> 2));
            end
        end
    end
endmodule

// File: rtl/gpio_sync.sv
// gpio_sync: two-flop synchronizer for one bank of pins plus a third stage
// holding the previous synchronized level for edge detection.
// Assumes pin_in is asynchronous to clk; reset clears all stages.
module gpio_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] synced,
    output logic [W-1:0] prev
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;
    logic [W-1:0] prev_q;
    logic [1:0]   warm_q;

    // Shift pin levels through the synchronizer and the history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pin_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    // Count edges since reset so latency checks start once history is valid.
    always_ff @(posedge clk) begin
        if (!rst_n)                warm_q <= 2'd0;
        else if (warm_q != 2'd3)   warm_q <= warm_q + 2'd1;
    end

    assign synced = sync_q;
    assign prev   = prev_q;

    // R5: the synchronized level is the pin level from two edges earlier.
    assert_sync_two_stage_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd3) |-> (synced == $past(pin_in, 2)));

    // R8: the history stage lags the synchronized level by one edge.
    assert_prev_lag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd3) |-> (prev == $past(synced)));
endmodule

// File: rtl/gpio_bank.sv
// gpio_bank: register file of one bank of W pins (W <= 32): direction,
// output latch with set/clear access, edge enables and sticky status.
// Assumes wr_en is already qualified for this bank and that synced/prev come
// from the bank's synchronizer. Unpopulated bits simply do not exist here.
module gpio_bank
    import gpio_pkg::*;
#(
    parameter int W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  gpio_reg_e         regsel,
    input  logic [W-1:0]      wdata,
    input  logic [W-1:0]      synced,
    input  logic [W-1:0]      prev,
    output logic [BUS_W-1:0]  rdata,
    output logic [W-1:0]      out_lvl,
    output logic [W-1:0]      dir_lvl,
    output logic              irq_bank
);
    logic [W-1:0] dir_q;
    logic [W-1:0] out_q;
    logic [W-1:0] rise_q;
    logic [W-1:0] fall_q;
    logic [W-1:0] stat_q;
    logic [W-1:0] edge_ev;
    logic [W-1:0] stat_clr;

    // Direction register: 1 = input, reset to all inputs.
    always_ff @(posedge clk) begin
        if (!rst_n)                              dir_q <= '1;
        else if (wr_en && (regsel == REG_DIR))   dir_q <= wdata;
    end

    // Output latch: whole-word write, write-one-set and write-one-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else if (wr_en) begin
            case (regsel)
                REG_OUT: out_q <= wdata;
                REG_SET: out_q <= out_q | wdata;
                REG_CLR: out_q <= out_q & ~wdata;
                default: out_q <= out_q;
            endcase
        end
    end

    // Rising and falling edge enable masks with set/clear access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_q <= '0;
            fall_q <= '0;
        end else if (wr_en) begin
            case (regsel)
                REG_RISE_SET: rise_q <= rise_q | wdata;
                REG_RISE_CLR: rise_q <= rise_q & ~wdata;
                REG_FALL_SET: fall_q <= fall_q | wdata;
                REG_FALL_CLR: fall_q <= fall_q & ~wdata;
                default: begin
                    rise_q <= rise_q;
                    fall_q <= fall_q;
                end
            endcase
        end
    end

    // Enabled edges of the synchronized level.
    always_comb begin
        edge_ev = (synced & ~prev & rise_q) | (~synced & prev & fall_q);
    end

    // Write-one-to-clear mask for the status register.
    always_comb begin
        stat_clr = (wr_en && (regsel == REG_STAT)) ? wdata : '0;
    end

    // Sticky status: a new edge wins over a simultaneous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~stat_clr) | edge_ev;
    end

    // Read multiplexer, zero-extended to the bus width.
    always_comb begin
        case (regsel)
            REG_DIR:                   rdata = BUS_W'(dir_q);
            REG_OUT, REG_SET, REG_CLR: rdata = BUS_W'(out_q);
            REG_IN:                    rdata = BUS_W'(synced);
            REG_RISE_SET, REG_RISE_CLR: rdata = BUS_W'(rise_q);
            REG_FALL_SET, REG_FALL_CLR: rdata = BUS_W'(fall_q);
            REG_STAT:                  rdata = BUS_W'(stat_q);
            default:                   rdata = '0;
        endcase
    end

    assign out_lvl  = out_q;
    assign dir_lvl  = dir_q;
    assign irq_bank = |stat_q;

    // R2: direction holds unless the direction register is written.
    assert_dir_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (regsel == REG_DIR)) |=> $stable(dir_q));

    // R3: every written one is set in the latch afterwards.
    assert_set_ones_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (regsel == REG_SET)) |=> ((out_q & $past(wdata)) == $past(wdata)));

    // R4: every written one is clear in the latch afterwards.
    assert_clr_ones_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (regsel == REG_CLR)) |=> ((out_q & $past(wdata)) == '0));

    // R8: a status bit only rises after an enabled edge was seen.
    assert_stat_needs_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_q & ~$past(stat_q)) != '0) |-> ($past(edge_ev) != '0));
endmodule

// File: rtl/gpio_bank_ctrl.sv
// gpio_bank_ctrl: top of the banked GPIO controller. Splits NUM_PINS into
// banks of 32 (the last one partial), gives each bank a synchronizer and a
// register file, decodes the word bus and combines the bank interrupts.
// Assumes NUM_PINS is 1..160 and ADDR_W reaches the last bank window.
module gpio_bank_ctrl
    import gpio_pkg::*;
#(
    parameter int NUM_PINS = 144,
    parameter int ADDR_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr_en,
    input  logic [BUS_W-1:0]    bus_wdata,
    output logic [BUS_W-1:0]    bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic                irq
);
    localparam int NUM_BANKS = (NUM_PINS + PINS_PER_BANK - 1) / PINS_PER_BANK;

    gpio_dec_t            dec;
    logic [BUS_W-1:0]     bank_rdata [NUM_BANKS];
    logic [NUM_BANKS-1:0] bank_irq;

    gpio_addr_dec #(
        .ADDR_W    (ADDR_W),
        .NUM_BANKS (NUM_BANKS)
    ) dec_i (
        .addr (bus_addr),
        .dec  (dec)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam int LO = b * PINS_PER_BANK;
        localparam int BW = ((NUM_PINS - LO) > PINS_PER_BANK) ? PINS_PER_BANK : (NUM_PINS - LO);

        logic [BW-1:0] synced;
        logic [BW-1:0] prev;
        logic [BW-1:0] out_lvl;
        logic [BW-1:0] dir_lvl;
        logic          wr_sel;

        // Qualify the bus write strobe for this bank.
        assign wr_sel = bus_wr_en && dec.hit && (dec.bank == 3'(b));

        gpio_sync #(.W(BW)) sync_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin_in (pin_in[LO +: BW]),
            .synced (synced),
            .prev   (prev)
        );

        gpio_bank #(.W(BW)) bank_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_sel),
            .regsel   (dec.regsel),
            .wdata    (bus_wdata[BW-1:0]),
            .synced   (synced),
            .prev     (prev),
            .rdata    (bank_rdata[b]),
            .out_lvl  (out_lvl),
            .dir_lvl  (dir_lvl),
            .irq_bank (bank_irq[b])
        );

        assign pin_out[LO +: BW] = out_lvl;
        assign pin_oe[LO +: BW]  = ~dir_lvl;
    end

    // Select the addressed bank's read data; misses read zero.
    always_comb begin
        bus_rdata = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (dec.hit && (dec.bank == 3'(b))) bus_rdata = bank_rdata[b];
        end
    end

    assign irq = |bank_irq;
endmodule

// File: tb/gpio_bank_ctrl_tb.sv
// gpio_bank_ctrl_tb_top: behavioural model compared with the controller on
// every clock, plus directed sequences for each requirement.
module gpio_bank_ctrl_tb_top;
    localparam int NP = 80;
    localparam int AW = 8;
    localparam int NB = (NP + 31) / 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] bus_addr;
    logic          bus_wr_en;
    logic [31:0]   bus_wdata;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pin_in;
    logic [NP-1:0] pin_out;
    logic [NP-1:0] pin_oe;
    logic          irq;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    gpio_bank_ctrl #(.NUM_PINS(NP), .ADDR_W(AW)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr_en (bus_wr_en),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .irq       (irq)
    );

    // ---------------- reference model ----------------
    logic [31:0]   m_dir  [NB];
    logic [31:0]   m_out  [NB];
    logic [31:0]   m_rise [NB];
    logic [31:0]   m_fall [NB];
    logic [31:0]   m_stat [NB];
    logic [NP-1:0] hist [$];   // pin levels seen at past edges, newest first

    function automatic logic [31:0] bmask(int b);
        if ((b + 1) * 32 <= NP) return 32'hFFFF_FFFF;
        return (32'h1 << (NP - b * 32)) - 32'h1;
    endfunction

    function automatic int bank_of(logic [AW-1:0] a);
        int o;
        if (a[1:0] != 2'b00 || int'(a) < 16) return -1;
        o = int'(a) - 16;
        if (o / 40 >= NB) return -1;
        return o / 40;
    endfunction

    function automatic int reg_of(logic [AW-1:0] a);
        return ((int'(a) - 16) % 40) / 4;
    endfunction

    function automatic logic [31:0] word_of(logic [NP-1:0] v, int b);
        logic [NP+31:0] t;
        t = {32'b0, v} >> (b * 32);
        return t[31:0] & bmask(b);
    endfunction

    function automatic logic [31:0] model_read(logic [AW-1:0] a);
        int b;
        b = bank_of(a);
        if (b < 0) return 32'h0;
        case (reg_of(a))
            0:       return m_dir[b];
            1, 2, 3: return m_out[b];
            4:       return word_of(hist[1], b);
            5, 6:    return m_rise[b];
            7, 8:    return m_fall[b];
            9:       return m_stat[b];
            default: return 32'h0;
        endcase
    endfunction

    logic [31:0] s_w, p_w, ev_w, clr_w, wd_w;
    int wb, wr;
    // Model update at each rising edge from the inputs driven at the negedge.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < NB; b++) begin
                m_dir[b] = bmask(b); m_out[b] = 0; m_rise[b] = 0;
                m_fall[b] = 0; m_stat[b] = 0;
            end
            hist.delete();
            repeat (4) hist.push_back('0);
        end else begin
            wb = bus_wr_en ? bank_of(bus_addr) : -1;
            wr = reg_of(bus_addr);
            wd_w = (wb >= 0) ? (bus_wdata & bmask(wb)) : 32'h0;
            for (int b = 0; b < NB; b++) begin
                s_w  = word_of(hist[1], b);
                p_w  = word_of(hist[2], b);
                ev_w = (s_w & ~p_w & m_rise[b]) | (~s_w & p_w & m_fall[b]);
                clr_w = (wb == b && wr == 9) ? wd_w : 32'h0;
                m_stat[b] = (m_stat[b] & ~clr_w) | ev_w;
            end
            if (wb >= 0) begin
                case (wr)
                    0: m_dir[wb]  = wd_w;
                    1: m_out[wb]  = wd_w;
                    2: m_out[wb]  = m_out[wb] | wd_w;
                    3: m_out[wb]  = m_out[wb] & ~wd_w;
                    5: m_rise[wb] = m_rise[wb] | wd_w;
                    6: m_rise[wb] = m_rise[wb] & ~wd_w;
                    7: m_fall[wb] = m_fall[wb] | wd_w;
                    8: m_fall[wb] = m_fall[wb] & ~wd_w;
                    default: ;
                endcase
            end
            hist.push_front(pin_in);
            void'(hist.pop_back());
        end
    end

    // ---------------- checking ----------------
    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk_vec(string tag, logic [NP-1:0] act, logic [NP-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        logic [NP-1:0] e_out, e_oe;
        logic any;
        if (!rst_n) return;
        any = 1'b0;
        for (int i = 0; i < NP; i++) begin
            e_out[i] = m_out[i / 32][i % 32];
            e_oe[i]  = ~m_dir[i / 32][i % 32];
        end
        for (int b = 0; b < NB; b++) any = any | (|m_stat[b]);
        chk_vec("R2 pin_oe per cycle", pin_oe, e_oe);
        chk_vec("R3 pin_out per cycle", pin_out, e_out);
        chk("R9 irq per cycle", {31'b0, irq}, {31'b0, any});
        chk("R6 rdata per cycle", bus_rdata, model_read(bus_addr));
    endtask

    task automatic tick(logic [AW-1:0] a, logic we, logic [31:0] d);
        @(negedge clk);
        compare_all();
        bus_addr  = a;
        bus_wr_en = we;
        bus_wdata = d;
    endtask

    task automatic rd(logic [AW-1:0] a, string tag, logic [31:0] exp);
        tick(a, 1'b0, 32'h0);
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic idle(int n);
        repeat (n) tick(8'h00, 1'b0, 32'h0);
    endtask

    // Watchdog: a hung run is a failed check and still prints the summary.
    initial begin
        #(200000 * 4);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; bus_addr = '0; bus_wr_en = 1'b0; bus_wdata = '0; pin_in = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        rd(8'h10, "R1 dir reset bank0", 32'hFFFF_FFFF);
        rd(8'h14, "R1 out reset", 32'h0);
        rd(8'h24, "R1 rise enable reset", 32'h0);
        rd(8'h34, "R1 status reset", 32'h0);
        chk_vec("R1 pin_oe reset", pin_oe, '0);
        chk("R1 irq reset", {31'b0, irq}, 32'h0);

        // R2: direction polarity
        tick(8'h10, 1'b1, 32'h0000_FFFF);
        rd(8'h10, "R2 dir readback", 32'h0000_FFFF);
        chk("R2 oe follows inverted dir", pin_oe[31:0], 32'hFFFF_0000);

        // R6 / R3 / R4: latch write, set, clear
        tick(8'h14, 1'b1, 32'h1234_5678);
        rd(8'h14, "R6 out data write", 32'h1234_5678);
        tick(8'h18, 1'b1, 32'h0000_000F);
        rd(8'h14, "R3 set data", 32'h1234_567F);
        tick(8'h1C, 1'b1, 32'h0000_0070);
        rd(8'h14, "R4 clear data", 32'h1234_560F);
        rd(8'h18, "R6 set reg reads latch", 32'h1234_560F);
        chk("R3 pin_out shows latch", pin_out[31:0], 32'h1234_560F);

        // R5: synchronizer latency, outputs included
        pin_in[31:0] = 32'hA5A5_A5A5;
        rd(8'h20, "R5 input still old one edge later", 32'h0);
        rd(8'h20, "R5 input after two edges", 32'hA5A5_A5A5);

        // R7: enable masks
        tick(8'h24, 1'b1, 32'h1);
        tick(8'h2C, 1'b1, 32'h2);
        rd(8'h28, "R7 rise clear reads mask", 32'h1);
        rd(8'h2C, "R7 fall mask", 32'h2);

        // R8 / R9: rising edge on pin 0
        pin_in[0] = 1'b0;
        idle(4);
        rd(8'h34, "R8 falling edge not enabled for pin0", 32'h0);
        pin_in[0] = 1'b1;
        idle(2);
        chk("R8 status not yet set two edges after change", {31'b0, irq}, 32'h0);
        rd(8'h34, "R8 rising edge sets status", 32'h1);
        chk("R9 irq high", {31'b0, irq}, 32'h1);
        tick(8'h34, 1'b1, 32'h1);
        rd(8'h34, "R8 write one clears status", 32'h0);
        chk("R9 irq low", {31'b0, irq}, 32'h0);

        // R7: disabled rise no longer reports
        tick(8'h28, 1'b1, 32'h1);
        pin_in[0] = 1'b0; idle(4);
        pin_in[0] = 1'b1; idle(4);
        rd(8'h34, "R7 disabled rising ignored", 32'h0);

        // R8: falling edge on pin 1
        pin_in[1] = 1'b1; idle(4);
        rd(8'h34, "R8 rise on fall-only pin ignored", 32'h0);
        pin_in[1] = 1'b0; idle(4);
        rd(8'h34, "R8 falling edge sets status", 32'h2);

        // R10: partial bank 2 (pins 64..79) at 0x60
        rd(8'h60, "R10 partial dir reset", 32'h0000_FFFF);
        tick(8'h60, 1'b1, 32'h0);
        rd(8'h60, "R10 partial dir cleared", 32'h0);
        chk("R10 partial oe", {16'h0, pin_oe[79:64]}, 32'h0000_FFFF);
        tick(8'h68, 1'b1, 32'hFFFF_FFFF);
        rd(8'h64, "R10 partial set masked", 32'h0000_FFFF);

        // R11: unmapped and misaligned
        tick(8'h88, 1'b1, 32'hFFFF_FFFF);
        rd(8'h88, "R11 unpopulated bank reads zero", 32'h0);
        rd(8'h0C, "R11 below first bank", 32'h0);
        tick(8'h15, 1'b1, 32'h0);
        rd(8'h14, "R11 misaligned write ignored", 32'h1234_560F);
        rd(8'h16, "R11 misaligned read zero", 32'h0);

        // Random traffic, compared every cycle against the model.
        for (int i = 0; i < 4000; i++) begin
            logic [AW-1:0] a;
            a = 8'((($urandom % 56) * 4));
            if ($urandom % 7 == 0) a = a | 8'h1;
            if ($urandom % 4 == 0) pin_in = {$urandom, $urandom, $urandom};
            tick(a, 1'((($urandom % 2))), $urandom);
        end
        idle(3);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule